// File: doc/BRIEF.md
# Sectioned Multiply-Accumulator with Preload

This block multiplies two 12-bit operands and folds the product into a 27-bit accumulator. Each step can add the product to the running total, subtract the running total from the product, or replace the total with the product. Operands may be read as two's complement or as unsigned numbers. An optional rounding bit adds one half of the least-significant section's weight to the product. Operand A is captured with its own clock and operand B with a separate clock. The accumulator moves only on the result clock.

The accumulator is split into three sections that can each reach a shared bidirectional result bus: a 3-bit extension (bits 26..24), a 12-bit upper section (bits 23..12) and a 12-bit lower section (bits 11..0). Each section has its own active-low enable. With the preload strobe low, an enable decides whether its section drives the bus. With the strobe high, no section drives, and each section whose enable is high loads its slice from the bus instead of taking the arithmetic result. The tri-state bus is modelled as three vectors: the data leaving the block, a per-bit drive enable, and the data arriving from the bus.

Top module: `mac_sectioned`

## Requirements
- R1: Operand A and the controls (format, operation, rounding) are captured on the rising edge of `clk_a`. Operand B is captured on the rising edge of `clk_b`. The accumulator, seen on `r_out`, changes only on the rising edge of `clk_r`.
- R2: With captured `tc`=1, both operands are two's complement and the product is sign-extended to 27 bits. With `tc`=0, both are unsigned and the product is zero-extended.
- R3: With captured `acc`=1 and `sub`=0, the next accumulator is the old accumulator plus the product, modulo 2^27.
- R4: With captured `acc`=1 and `sub`=1, the next accumulator is the product minus the old accumulator, modulo 2^27.
- R5: With captured `acc`=0 and `sub`=0, the next accumulator is the product alone. The pair `acc`=0, `sub`=1 is left unspecified.
- R6: With captured `rnd`=1, 2^11 is added to the product before it is combined.
- R7: With `prel`=0, `r_oe[26:24]` is high exactly when `oe_n[2]` is low, `r_oe[23:12]` exactly when `oe_n[1]` is low, and `r_oe[11:0]` exactly when `oe_n[0]` is low. `r_out` always carries the accumulator.
- R8: With `prel`=1, every bit of `r_oe` is low.
- R9: With `prel`=1 on a `clk_r` edge, each section whose `oe_n` bit is high loads its slice of `r_in`. Each section whose bit is low takes its slice of the arithmetic result on that edge.
- R10: A synchronous active-high `rst` clears the operand registers, the control registers and all accumulator sections to zero on the edges of their clocks.
- R11: Changes on `a_in`, `tc`, `acc`, `sub` or `rnd` after the `clk_a` edge have no effect on the result formed at the next `clk_r` edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_a | input | 1 | Clock for operand A and the controls |
| clk_b | input | 1 | Clock for operand B |
| clk_r | input | 1 | Clock for the accumulator sections |
| rst | input | 1 | Synchronous reset, active high |
| a_in | input | 12 | Operand A |
| b_in | input | 12 | Operand B |
| tc | input | 1 | 1: two's complement operands, 0: unsigned |
| acc | input | 1 | Accumulate select |
| sub | input | 1 | Reverse-subtract select (with `acc`) |
| rnd | input | 1 | Add rounding bit at position 11 |
| prel | input | 1 | Preload strobe |
| oe_n | input | 3 | Active-low section enables: [2] extension, [1] upper, [0] lower |
| r_in | input | 27 | Data arriving from the result bus |
| r_out | output | 27 | Accumulator data toward the result bus |
| r_oe | output | 27 | Per-bit bus drive enable |

## Verification
The hardest case to reach is a partial preload. Here one section takes bus data while a neighbour takes the arithmetic result on the same edge, and the carry across the boundary must come from the old full accumulator and not from the preloaded value. The stimulus first sets a known total. It then captures an operation with small operands, raises the strobe with a mixed enable pattern, and drives a bus word whose slices differ from anything the arithmetic would produce. Finally it releases the strobe and reads the merged word. A second pass preloads only the extension during an add, so both sides of each section boundary get covered.

// File: rtl/mac_pkg.sv
package mac_pkg;

   // Operation code, encoded as {acc, sub}
   typedef enum logic [1:0] {
      OP_LOAD  = 2'b00,
      OP_UNDEF = 2'b01,
      OP_ADD   = 2'b10,
      OP_RSUB  = 2'b11
   } mac_op_e;

   typedef struct packed {
      logic    tc;
      logic    rnd;
      mac_op_e op;
   } mac_ctrl_t;

   localparam int NUM_SEC = 3;

   // Width of section k: 0 lower, 1 upper, 2 extension
   function automatic int sec_width(input int k, input int lw, input int mw, input int xw);
      return (k == 0) ? lw : ((k == 1) ? mw : xw);
   endfunction

   // Lowest bit of section k
   function automatic int sec_base(input int k, input int lw, input int mw);
      return (k == 0) ? 0 : ((k == 1) ? lw : lw + mw);
   endfunction

endpackage

// File: rtl/mac_in_reg.sv
module mac_in_reg #(
   parameter int W = 12
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   generate
      if (W < 1) begin : g_bad_w
         $error("mac_in_reg: W must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) q <= '0;
      else     q <= d;
   end

endmodule

// File: rtl/mac_product.sv
module mac_product #(
   parameter int A_W      = 12,
   parameter int B_W      = 12,
   parameter int ACC_W    = 27,
   parameter int RND_POS  = 11,
   parameter bit ROUND_EN = 1'b1
) (
   input  logic [A_W-1:0]   a,
   input  logic [B_W-1:0]   b,
   input  logic             tc,
   input  logic             rnd,
   output logic [ACC_W-1:0] prod
);

   localparam int PW = A_W + B_W + 2;

   logic signed [A_W:0]    a_x;
   logic signed [B_W:0]    b_x;
   logic signed [PW-1:0]   p_full;
   logic [ACC_W-1:0]       p_ext;

   // One extra bit per operand: sign copy in two's complement, zero otherwise
   assign a_x    = {tc & a[A_W-1], a};
   assign b_x    = {tc & b[B_W-1], b};
   assign p_full = a_x * b_x;

   generate
      if (RND_POS >= ACC_W) begin : g_bad_rnd
         $error("mac_product: RND_POS must lie inside the accumulator");
      end
      if (ACC_W > PW) begin : g_widen
         assign p_ext = {{(ACC_W-PW){p_full[PW-1]}}, p_full};
      end else begin : g_trim
         assign p_ext = p_full[ACC_W-1:0];
      end
      if (ROUND_EN) begin : g_round
         logic [ACC_W-1:0] rnd_term;
         assign rnd_term = rnd ? (ACC_W'(1) << RND_POS) : '0;
         assign prod     = p_ext + rnd_term;
      end else begin : g_noround
         logic unused_rnd;
         assign unused_rnd = rnd;
         assign prod       = p_ext;
      end
   endgenerate

endmodule

// File: rtl/mac_combine.sv
module mac_combine
   import mac_pkg::*;
#(
   parameter int ACC_W = 27
) (
   input  mac_op_e          op,
   input  logic [ACC_W-1:0] acc_cur,
   input  logic [ACC_W-1:0] prod,
   output logic [ACC_W-1:0] acc_nxt
);

   always_comb begin
      unique case (op)
         OP_ADD:  acc_nxt = acc_cur + prod;
         OP_RSUB: acc_nxt = prod - acc_cur;
         default: acc_nxt = prod;   // load, and the unspecified pair
      endcase
   end

endmodule

// File: rtl/mac_section.sv
module mac_section #(
   parameter int W = 12
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         prel,
   input  logic         en_n,
   input  logic [W-1:0] arith,
   input  logic [W-1:0] bus_in,
   output logic [W-1:0] q,
   output logic [W-1:0] drv
);

   logic take_bus;

   assign take_bus = prel & en_n;
   assign drv      = {W{~prel & ~en_n}};

   always_ff @(posedge clk) begin
      if (rst)           q <= '0;
      else if (take_bus) q <= bus_in;
      else               q <= arith;
   end

endmodule

// File: rtl/mac_sectioned.sv
module mac_sectioned
   import mac_pkg::*;
#(
   parameter int A_W      = 12,
   parameter int B_W      = 12,
   parameter int L_W      = 12,
   parameter int M_W      = 12,
   parameter int X_W      = 3,
   parameter bit ROUND_EN = 1'b1
) (
   input  logic                     clk_a,
   input  logic                     clk_b,
   input  logic                     clk_r,
   input  logic                     rst,
   input  logic [A_W-1:0]           a_in,
   input  logic [B_W-1:0]           b_in,
   input  logic                     tc,
   input  logic                     acc,
   input  logic                     sub,
   input  logic                     rnd,
   input  logic                     prel,
   input  logic [2:0]               oe_n,
   input  logic [L_W+M_W+X_W-1:0]   r_in,
   output logic [L_W+M_W+X_W-1:0]   r_out,
   output logic [L_W+M_W+X_W-1:0]   r_oe
);

   localparam int ACC_W   = L_W + M_W + X_W;
   localparam int RND_POS = L_W - 1;
   localparam int CTRL_W  = $bits(mac_ctrl_t);

   generate
      if (ACC_W < A_W + B_W + 1) begin : g_bad_acc
         $error("mac_sectioned: accumulator narrower than a signed product");
      end
      if (L_W < 1 || M_W < 1 || X_W < 1) begin : g_bad_sec
         $error("mac_sectioned: every section needs at least one bit");
      end
   endgenerate

   logic [A_W-1:0]    a_q;
   logic [B_W-1:0]    b_q;
   logic [CTRL_W-1:0] ctrl_d;
   logic [CTRL_W-1:0] ctrl_qv;
   mac_ctrl_t         ctrl_q;
   mac_op_e           cap_op;
   logic [ACC_W-1:0]  prod_w;
   logic [ACC_W-1:0]  acc_q;
   logic [ACC_W-1:0]  acc_nxt;

   // Operand A and the controls share clk_a; operand B has clk_b
   mac_in_reg #(.W(A_W)) u_reg_a (
      .clk (clk_a), .rst (rst), .d (a_in), .q (a_q)
   );

   mac_in_reg #(.W(B_W)) u_reg_b (
      .clk (clk_b), .rst (rst), .d (b_in), .q (b_q)
   );

   assign ctrl_d = {tc, rnd, acc, sub};

   mac_in_reg #(.W(CTRL_W)) u_reg_ctrl (
      .clk (clk_a), .rst (rst), .d (ctrl_d), .q (ctrl_qv)
   );

   assign ctrl_q = mac_ctrl_t'(ctrl_qv);
   assign cap_op = ctrl_q.op;

   mac_product #(
      .A_W      (A_W),
      .B_W      (B_W),
      .ACC_W    (ACC_W),
      .RND_POS  (RND_POS),
      .ROUND_EN (ROUND_EN)
   ) u_prod (
      .a    (a_q),
      .b    (b_q),
      .tc   (ctrl_q.tc),
      .rnd  (ctrl_q.rnd),
      .prod (prod_w)
   );

   mac_combine #(.ACC_W(ACC_W)) u_comb (
      .op      (cap_op),
      .acc_cur (acc_q),
      .prod    (prod_w),
      .acc_nxt (acc_nxt)
   );

   for (genvar k = 0; k < NUM_SEC; k++) begin : g_sec
      localparam int SW = sec_width(k, L_W, M_W, X_W);
      localparam int SB = sec_base(k, L_W, M_W);

      mac_section #(.W(SW)) u_sec (
         .clk    (clk_r),
         .rst    (rst),
         .prel   (prel),
         .en_n   (oe_n[k]),
         .arith  (acc_nxt[SB +: SW]),
         .bus_in (r_in[SB +: SW]),
         .q      (acc_q[SB +: SW]),
         .drv    (r_oe[SB +: SW])
      );
   end

   assign r_out = acc_q;

endmodule

// File: rtl/mac_sectioned_chk.sv
module mac_sectioned_chk #(
   parameter int ACC_W = 27,
   parameter int L_W   = 12,
   parameter int X_W   = 3
) (
   input logic             clk_r,
   input logic             rst,
   input logic             prel,
   input logic [2:0]       oe_n,
   input logic [ACC_W-1:0] r_in,
   input logic [ACC_W-1:0] r_out,
   input logic [ACC_W-1:0] r_oe,
   input logic [1:0]       cap_op,
   input logic [ACC_W-1:0] prod
);

   p_hiz_prel_r8: assert property (@(posedge clk_r) disable iff (rst)
      prel |-> (r_oe == '0));

   p_drive_low_r7: assert property (@(posedge clk_r) disable iff (rst)
      !prel |-> (r_oe[L_W-1:0] == {L_W{~oe_n[0]}}));

   p_drive_ext_r7: assert property (@(posedge clk_r) disable iff (rst)
      !prel |-> (r_oe[ACC_W-1 -: X_W] == {X_W{~oe_n[2]}}));

   p_preload_low_r9: assert property (@(posedge clk_r) disable iff (rst)
      (prel && oe_n[0]) |=> (r_out[L_W-1:0] == $past(r_in[L_W-1:0])));

   p_load_r5: assert property (@(posedge clk_r) disable iff (rst)
      (!prel && cap_op == 2'b00) |=> (r_out == $past(prod)));

   p_add_r3: assert property (@(posedge clk_r) disable iff (rst)
      (!prel && cap_op == 2'b10) |=> (r_out == $past(r_out + prod)));

   p_rsub_r4: assert property (@(posedge clk_r) disable iff (rst)
      (!prel && cap_op == 2'b11) |=> (r_out == $past(prod - r_out)));

   p_reset_clear_r10: assert property (@(posedge clk_r)
      rst |=> (r_out == '0));

endmodule

bind mac_sectioned mac_sectioned_chk #(
   .ACC_W (ACC_W),
   .L_W   (L_W),
   .X_W   (X_W)
) u_chk (
   .clk_r  (clk_r),
   .rst    (rst),
   .prel   (prel),
   .oe_n   (oe_n),
   .r_in   (r_in),
   .r_out  (r_out),
   .r_oe   (r_oe),
   .cap_op (cap_op),
   .prod   (prod_w)
);

// File: tb/tb_mac_sectioned.sv
module tb_mac_sectioned;

   localparam int CLK_PERIOD = 10;
   localparam int NV         = 12;

   typedef struct packed {
      logic [11:0] a;
      logic [11:0] b;
      logic        tc;
      logic        acc;
      logic        sub;
      logic        rnd;
      logic [26:0] exp;
   } vec_t;

   // Chained: each expected value starts from the previous one (start 0)
   localparam vec_t VECS [NV] = '{
      '{12'h003, 12'h005, 1'b0, 1'b0, 1'b0, 1'b0, 27'h000000F},  // load 15
      '{12'hFFE, 12'h007, 1'b1, 1'b1, 1'b0, 1'b0, 27'h0000001},  // +(-14)
      '{12'hFFE, 12'h007, 1'b0, 1'b0, 1'b0, 1'b0, 27'h0006FF2},  // 4094*7
      '{12'h064, 12'h003, 1'b0, 1'b1, 1'b1, 1'b0, 27'h7FF913A},  // 300-acc
      '{12'h001, 12'h001, 1'b0, 1'b0, 1'b0, 1'b1, 27'h0000801},  // 1+2^11
      '{12'h800, 12'h800, 1'b1, 1'b0, 1'b0, 1'b0, 27'h0400000},  // (-2048)^2
      '{12'h800, 12'h800, 1'b1, 1'b1, 1'b0, 1'b0, 27'h0800000},  // add again
      '{12'h800, 12'h7FF, 1'b1, 1'b1, 1'b0, 1'b0, 27'h0400800},  // add negative
      '{12'hFFF, 12'hFFF, 1'b0, 1'b0, 1'b0, 1'b0, 27'h0FFE001},  // 4095^2
      '{12'hFFF, 12'hFFF, 1'b0, 1'b1, 1'b0, 1'b0, 27'h1FFC002},  // add
      '{12'hFFF, 12'hFFF, 1'b1, 1'b1, 1'b1, 1'b0, 27'h6003FFF},  // 1-acc wraps
      '{12'hFFF, 12'h001, 1'b1, 1'b0, 1'b0, 1'b1, 27'h00007FF}   // -1+2^11
   };

   logic clk = 1'b0;
   logic en_a = 1'b0, en_b = 1'b0, en_r = 1'b0;
   logic clk_a, clk_b, clk_r;
   logic rst = 1'b1;
   logic [11:0] a_in = '0, b_in = '0;
   logic tc = 1'b0, acc = 1'b0, sub = 1'b0, rnd = 1'b0, prel = 1'b0;
   logic [2:0]  oe_n = 3'b000;
   logic [26:0] r_in = '0;
   logic [26:0] r_out, r_oe;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;
   assign clk_a = clk & en_a;
   assign clk_b = clk & en_b;
   assign clk_r = clk & en_r;

   mac_sectioned dut (
      .clk_a (clk_a), .clk_b (clk_b), .clk_r (clk_r), .rst (rst),
      .a_in (a_in), .b_in (b_in), .tc (tc), .acc (acc), .sub (sub),
      .rnd (rnd), .prel (prel), .oe_n (oe_n), .r_in (r_in),
      .r_out (r_out), .r_oe (r_oe)
   );

   task automatic check(input string req, input string what,
                        input logic [26:0] got, input logic [26:0] exp);
      n_checks++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
      end
   endtask

   // Called at a falling edge; gives one rising edge to the chosen clocks
   task automatic pulse(input logic ea, input logic eb, input logic er);
      en_a = ea; en_b = eb; en_r = er;
      @(posedge clk);
      @(negedge clk);
      en_a = 1'b0; en_b = 1'b0; en_r = 1'b0;
   endtask

   function automatic string vec_req(input vec_t v);
      if (v.rnd)          return "R6";
      if (v.tc)           return "R2";
      if (v.acc && v.sub) return "R4";
      if (v.acc)          return "R3";
      return "R5";
   endfunction

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
         $finish;
      end
   endtask

   initial begin
      #(CLK_PERIOD * 20000);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
   end

   initial begin
      @(negedge clk);
      rst = 1'b1;
      pulse(1'b1, 1'b1, 1'b1);
      pulse(1'b1, 1'b1, 1'b1);
      rst = 1'b0;
      check("R10", "reset accumulator", r_out, 27'h0);
      check("R7", "all sections driven", r_oe, {27{1'b1}});

      // Vector table: capture, then one result-clock edge
      for (int i = 0; i < NV; i++) begin
         a_in = VECS[i].a; b_in = VECS[i].b; tc = VECS[i].tc;
         acc = VECS[i].acc; sub = VECS[i].sub; rnd = VECS[i].rnd;
         pulse(1'b1, 1'b1, 1'b0);
         pulse(1'b0, 1'b0, 1'b1);
         check(vec_req(VECS[i]), $sformatf("vector %0d", i), r_out, VECS[i].exp);
      end

      // R1: operand edges alone leave the accumulator untouched
      a_in = 12'h123; b_in = 12'h456; tc = 1'b0; acc = 1'b0; sub = 1'b0; rnd = 1'b0;
      pulse(1'b1, 1'b1, 1'b0);
      check("R1", "no result edge", r_out, 27'h00007FF);
      // R1: only clk_b moves; A keeps 0x123
      b_in = 12'h002;
      pulse(1'b0, 1'b1, 1'b0);
      pulse(1'b0, 1'b0, 1'b1);
      check("R1", "B alone recaptured", r_out, 27'h0000246);

      // R11: inputs changed after capture are ignored
      a_in = 12'h002; b_in = 12'h003; tc = 1'b0; acc = 1'b0; sub = 1'b0; rnd = 1'b0;
      pulse(1'b1, 1'b1, 1'b0);
      a_in = 12'hFFF; tc = 1'b1; acc = 1'b1; sub = 1'b1; rnd = 1'b1;
      pulse(1'b0, 1'b0, 1'b1);
      check("R11", "late control change", r_out, 27'h0000006);

      // R7: enable mapping per section
      oe_n = 3'b101;
      #1 check("R7", "only upper driven", r_oe, {3'b000, 12'hFFF, 12'h000});
      oe_n = 3'b010;
      #1 check("R7", "upper released", r_oe, {3'b111, 12'h000, 12'hFFF});
      oe_n = 3'b111;
      #1 check("R7", "none driven", r_oe, 27'h0);

      // R8 / R9: preload lower and upper during a load of 6
      a_in = 12'h002; b_in = 12'h003; tc = 1'b0; acc = 1'b0; sub = 1'b0; rnd = 1'b0;
      pulse(1'b1, 1'b1, 1'b0);
      prel = 1'b1; oe_n = 3'b011; r_in = 27'h7123456;
      #1 check("R8", "preload floats bus", r_oe, 27'h0);
      @(negedge clk);
      pulse(1'b0, 1'b0, 1'b1);
      prel = 1'b0; oe_n = 3'b000;
      check("R9", "lower+upper preloaded", r_out, 27'h0123456);

      // R9: preload extension only while adding 6
      acc = 1'b1; sub = 1'b0;
      pulse(1'b1, 1'b1, 1'b0);
      prel = 1'b1; oe_n = 3'b100; r_in = 27'h5000000;
      pulse(1'b0, 1'b0, 1'b1);
      prel = 1'b0; oe_n = 3'b000;
      check("R9", "extension preloaded", r_out, 27'h512345C);

      // R10: mid-run reset clears accumulator and captured inputs
      a_in = 12'h005; b_in = 12'h005; acc = 1'b1; sub = 1'b0; rnd = 1'b1;
      rst = 1'b1;
      pulse(1'b1, 1'b1, 1'b1);
      rst = 1'b0;
      check("R10", "cleared after reset", r_out, 27'h0);
      pulse(1'b0, 1'b0, 1'b1);
      check("R10", "captured inputs cleared", r_out, 27'h0);

      finish_run();
   end

endmodule